// File: doc/BRIEF.md
# Latched Split-Mode Event Counter Bank

This block is a bank of event counters that software reaches over a 64-bit register bus. It has four physical counters of 32 bits. A control bit for each one lets that physical counter run instead as two independent 16-bit halves. This gives eight logical counters. Each logical counter has its own event input. A counter advances by one on every clock in which the bank is enabled and its event input is high.

Software never writes a running counter directly. A write goes into a holding latch for that physical counter. The latch is copied into the live counter only when the control register is written with its enable bit set. Rewriting the control register with enable set copies the latch again, so new values can be loaded while the bank is running.

Each overflow sets a sticky status bit. Reading the status register returns those bits and clears them in the same access. Writing the status register sets the interrupt enable mask. The interrupt output is high when any status bit is set and also enabled in the mask.

Top module: `perfmon_bank`

## Requirements
- R1: After reset, all counters, latches, the control register, the status bits and the interrupt mask are zero. The interrupt output is low and the read data is zero.
- R2: A register value sits in the upper 32 bits of the 64-bit bus word. Writes take only wdata[63:32]. Read data appears on rdata[63:32] one clock after the read strobe, and rdata[31:0] is always zero. The control register reads back the last value written to it.
- R3: A counter write loads only the holding latch and never changes the live count. If the bank is disabled when the write happens, that counter is marked pending, and readback returns the latch value until the next commit. A write made while the bank is enabled leaves readback showing the live count.
- R4: Writing the control register with bit 31 set commits: every latch written since the last commit is copied into its live counter, and all pending marks clear. This also happens when the bank is already enabled. Counters whose latch was not written keep their values. When a commit and an event fall in the same clock, the committed value wins.
- R5: While control bit 31 is 1, a counter adds one on each clock in which its event input is high. While bit 31 is 0, no counter changes on events.
- R6: When control bit p (of bits 3:0) is 0, physical counter p works as one 32-bit counter. Logical indices p and p+4 both read and write the full 32-bit value, and the counter counts on event input p. Counting past 0xFFFFFFFF wraps to 0 and sets status bit p.
- R7: When control bit p is 1, logical counter p is the upper 16 bits and counts on event input p. Logical counter p+4 is the lower 16 bits and counts on event input p+4. A 16-bit read returns the half, zero-extended. A 16-bit write replaces only its own half.
- R8: In split mode the lower half wraps from 0xFFFF to 0 without touching the upper half. An upper-half wrap sets status bit p, and a lower-half wrap sets status bit p+4.
- R9: A status read returns the overflow bits in [7:0] and clears them. An overflow that happens in the same clock as the read stays set.
- R10: A status write loads the interrupt mask from bits 7:0. The interrupt output is high exactly when some status bit is set and its mask bit is 1, so a zero mask keeps it low.
- R11: Word address 0 to 7 selects logical counters 0 to 7, address 8 selects the control register, and address 9 selects the status register. Writes to any other address are ignored, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 64 | Write data; register value in bits 63:32 |
| evt_in | input | 8 | Event input for each logical counter |
| bus_rdata | output | 64 | Registered read data; value in bits 63:32 |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The bench targets the following cases:
- Readback of a latch written while the bank is disabled, and readback of the live count after a write made while the bank is enabled. A design that mixed these up would return stale or premature values.
- Re-commit while already enabled, and a commit that lands in the same clock as an event. A wrong priority would leave the count one too high.
- A lower-half wrap in split mode. A carry leaking into the upper half would show up as an upper half that has changed.
- A status read that coincides with a new overflow. A clear-wins design would lose that overflow.
- A zero mask write with status still pending. This must drop the interrupt at once.

// File: rtl/perfmon_pkg.sv
// Package: shared access decode type for the counter bank.
// Assumes the register map is counters, then control, then status.
package perfmon_pkg;
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_CNT  = 2'd1,
        ACC_CTRL = 2'd2,
        ACC_STAT = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/perfmon_counter.sv
// One physical counter: either a full-width counter or two halves with no
// carry between them. A load from the commit path overrides counting.
// Assumes CNT_W is even.
module perfmon_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             split,
    input  logic             evt_hi,
    input  logic             evt_lo,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] value,
    output logic             ovf_hi,
    output logic             ovf_lo
);
    localparam int HW = CNT_W / 2;

    logic [HW-1:0]    hi_next, lo_next;
    logic [CNT_W-1:0] full_next;
    logic             hi_full, lo_full, all_full;

    // Purpose: compute incremented values and overflow flags for this clock.
    always_comb begin
        hi_full   = &value[CNT_W-1:HW];
        lo_full   = &value[HW-1:0];
        all_full  = &value;
        hi_next   = value[CNT_W-1:HW] + HW'(evt_hi);
        lo_next   = value[HW-1:0] + HW'(evt_lo);
        full_next = value + CNT_W'(evt_hi);
        ovf_hi    = run && !load && evt_hi && (split ? hi_full : all_full);
        ovf_lo    = run && !load && split && evt_lo && lo_full;
    end

    // Purpose: update the count; a load takes priority over events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (load)
            value <= load_val;
        else if (run)
            value <= split ? {hi_next, lo_next} : full_next;
    end
endmodule

// File: rtl/perfmon_status.sv
// Sticky overflow status with clear-on-read, interrupt mask and the masked
// interrupt line. A new overflow in the clearing clock is kept.
module perfmon_status #(
    parameter int N_LOG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LOG-1:0] ovf,
    input  logic             rd_clear,
    input  logic             mask_we,
    input  logic [N_LOG-1:0] mask_in,
    output logic [N_LOG-1:0] status,
    output logic [N_LOG-1:0] mask,
    output logic             irq
);
    // Purpose: accumulate overflows, clearing old bits on a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else if (rd_clear)
            status <= ovf;
        else
            status <= status | ovf;
    end

    // Purpose: hold the interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (mask_we)
            mask <= mask_in;
    end

    // Purpose: raise the interrupt for any enabled pending bit.
    always_comb irq = |(status & mask);
endmodule

// File: rtl/perfmon_regs.sv
// Register front end: decodes the bus, holds control, latches, and the
// dirty and pending flags, merges 16-bit writes, and registers read data.
// Assumes N_PHYS is a power of two and at least 2.
module perfmon_regs
    import perfmon_pkg::*;
#(
    parameter int N_PHYS = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_we,
    input  logic                         bus_re,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [CNT_W-1:0]             wr_word,
    input  logic [N_PHYS-1:0][CNT_W-1:0] live,
    input  logic [2*N_PHYS-1:0]          status,
    output logic                         ctrl_en,
    output logic [N_PHYS-1:0]            split,
    output logic                         commit,
    output logic [N_PHYS-1:0]            load,
    output logic [N_PHYS-1:0][CNT_W-1:0] latch,
    output logic [N_PHYS-1:0]            dirty,
    output logic [N_PHYS-1:0]            pending,
    output logic                         rd_clear,
    output logic                         mask_we,
    output logic [CNT_W-1:0]             rd_word
);
    localparam int N_LOG     = 2 * N_PHYS;
    localparam int HW        = CNT_W / 2;
    localparam int PIDX_W    = $clog2(N_PHYS);
    localparam int LIDX_W    = $clog2(N_LOG);
    localparam int ADDR_CTRL = N_LOG;
    localparam int ADDR_STAT = N_LOG + 1;

    acc_kind_e          kind;
    logic [CNT_W-1:0]   ctrl_q;
    logic [LIDX_W-1:0]  lidx;
    logic [PIDX_W-1:0]  pidx;
    logic               low_half;
    logic               cnt_we;
    logic [CNT_W-1:0]   base, merged, cur, rd_next;

    // Purpose: classify the addressed register.
    always_comb begin
        if (bus_addr < ADDR_W'(N_LOG))
            kind = ACC_CNT;
        else if (bus_addr == ADDR_W'(ADDR_CTRL))
            kind = ACC_CTRL;
        else if (bus_addr == ADDR_W'(ADDR_STAT))
            kind = ACC_STAT;
        else
            kind = ACC_NONE;
        lidx     = bus_addr[LIDX_W-1:0];
        pidx     = lidx[PIDX_W-1:0];
        low_half = lidx[LIDX_W-1];
    end

    // Purpose: derive strobes and control fields.
    always_comb begin
        cnt_we   = bus_we && (kind == ACC_CNT);
        commit   = bus_we && (kind == ACC_CTRL) && wr_word[CNT_W-1];
        mask_we  = bus_we && (kind == ACC_STAT);
        rd_clear = bus_re && (kind == ACC_STAT);
        ctrl_en  = ctrl_q[CNT_W-1];
        split    = ctrl_q[N_PHYS-1:0];
        load     = commit ? dirty : '0;
    end

    // Purpose: merge a half-width write with the other half of the counter.
    always_comb begin
        base = dirty[pidx] ? latch[pidx] : live[pidx];
        if (!split[pidx])
            merged = wr_word;
        else if (low_half)
            merged = {base[CNT_W-1:HW], wr_word[HW-1:0]};
        else
            merged = {wr_word[HW-1:0], base[HW-1:0]};
    end

    // Purpose: hold the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (bus_we && kind == ACC_CTRL)
            ctrl_q <= wr_word;
    end

    // Purpose: one latch and flag pair for each physical counter.
    for (genvar p = 0; p < N_PHYS; p++) begin : g_latch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                latch[p]   <= '0;
                dirty[p]   <= 1'b0;
                pending[p] <= 1'b0;
            end else if (commit) begin
                dirty[p]   <= 1'b0;
                pending[p] <= 1'b0;
            end else if (cnt_we && pidx == PIDX_W'(p)) begin
                latch[p]   <= merged;
                dirty[p]   <= 1'b1;
                pending[p] <= pending[p] | !ctrl_en;
            end
        end
    end

    // Purpose: select the read value for the addressed register.
    always_comb begin
        cur = pending[pidx] ? latch[pidx] : live[pidx];
        unique case (kind)
            ACC_CNT: begin
                if (!split[pidx])
                    rd_next = cur;
                else if (low_half)
                    rd_next = {{HW{1'b0}}, cur[HW-1:0]};
                else
                    rd_next = {{HW{1'b0}}, cur[CNT_W-1:HW]};
            end
            ACC_CTRL: rd_next = ctrl_q;
            ACC_STAT: rd_next = {{(CNT_W-N_LOG){1'b0}}, status};
            default:  rd_next = '0;
        endcase
    end

    // Purpose: register read data one clock after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_word <= '0;
        else if (bus_re)
            rd_word <= rd_next;
    end
endmodule

// File: rtl/perfmon_bank.sv
// Top of the event counter bank: wires the register front end, the
// physical counters and the status logic together.
// Assumes a single bus access per clock.
module perfmon_bank #(
    parameter int N_PHYS = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4,
    parameter int N_LOG  = 2 * N_PHYS,
    parameter int BUS_W  = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [N_LOG-1:0]  evt_in,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0]             wr_word;
    logic [CNT_W-1:0]             rd_word;
    logic                         unused_wlow;
    logic [N_PHYS-1:0][CNT_W-1:0] cnt_live;
    logic [N_PHYS-1:0][CNT_W-1:0] latch;
    logic [N_PHYS-1:0]            dirty, pending, split, load;
    logic [N_LOG-1:0]             ovf, status, mask;
    logic                         ctrl_en, commit, rd_clear, mask_we;

    // Purpose: place register values in the upper half of the bus word.
    always_comb begin
        wr_word     = bus_wdata[BUS_W-1:CNT_W];
        unused_wlow = ^bus_wdata[CNT_W-1:0];
        bus_rdata   = {rd_word, {CNT_W{1'b0}}};
    end

    perfmon_regs #(.N_PHYS(N_PHYS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .wr_word(wr_word), .live(cnt_live),
        .status(status), .ctrl_en(ctrl_en), .split(split), .commit(commit),
        .load(load), .latch(latch), .dirty(dirty), .pending(pending),
        .rd_clear(rd_clear), .mask_we(mask_we), .rd_word(rd_word)
    );

    for (genvar p = 0; p < N_PHYS; p++) begin : g_cnt
        perfmon_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .run(ctrl_en), .split(split[p]),
            .evt_hi(evt_in[p]), .evt_lo(evt_in[p+N_PHYS]),
            .load(load[p]), .load_val(latch[p]), .value(cnt_live[p]),
            .ovf_hi(ovf[p]), .ovf_lo(ovf[p+N_PHYS])
        );
    end

    perfmon_status #(.N_LOG(N_LOG)) u_status (
        .clk(clk), .rst_n(rst_n), .ovf(ovf), .rd_clear(rd_clear),
        .mask_we(mask_we), .mask_in(wr_word[N_LOG-1:0]),
        .status(status), .mask(mask), .irq(irq)
    );
endmodule

// File: rtl/perfmon_checker.sv
// Checker bound to the bank: temporal properties over counters, latches,
// status and interrupt. Assumes the default register map.
module perfmon_checker #(
    parameter int N_PHYS = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_we,
    input logic                         bus_re,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [CNT_W-1:0]             wr_word,
    input logic [2*N_PHYS-1:0]          evt_in,
    input logic                         ctrl_en,
    input logic                         commit,
    input logic [N_PHYS-1:0]            split,
    input logic [N_PHYS-1:0]            dirty,
    input logic [N_PHYS-1:0]            pending,
    input logic [N_PHYS-1:0][CNT_W-1:0] latch,
    input logic [N_PHYS-1:0][CNT_W-1:0] live,
    input logic [2*N_PHYS-1:0]          ovf,
    input logic [2*N_PHYS-1:0]          status,
    input logic                         irq
);
    localparam int HW        = CNT_W / 2;
    localparam int ADDR_STAT = 2 * N_PHYS + 1;

    AST_COMMIT_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> pending == '0); // R4

    AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == ADDR_W'(ADDR_STAT) && ovf == '0) |=> status == '0); // R9

    AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(ADDR_STAT) && wr_word == '0) |=> !irq); // R10

    for (genvar p = 0; p < N_PHYS; p++) begin : g_prop
        AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_en && !commit) |=> $stable(live[p])); // R5

        AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && dirty[p]) |=> live[p] == $past(latch[p])); // R4

        AST_NO_HALF_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_en && split[p] && !commit && !evt_in[p])
            |=> $stable(live[p][CNT_W-1:HW])); // R8
    end
endmodule

bind perfmon_bank perfmon_checker #(.N_PHYS(N_PHYS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .wr_word(wr_word), .evt_in(evt_in),
    .ctrl_en(ctrl_en), .commit(commit), .split(split), .dirty(dirty),
    .pending(pending), .latch(latch), .live(cnt_live), .ovf(ovf),
    .status(status), .irq(irq)
);

// File: tb/tb_perfmon_bank.sv
// Scoreboard bench: read tasks push expected words, a monitor pops and
// compares them when the registered read data appears.
module tb_perfmon_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [7:0]  evt_in = '0;
    logic [63:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        re_seen = 1'b0;
    bit          done = 1'b0;

    perfmon_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt_in(evt_in),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: note read strobes at the edge, compare at the falling edge.
    always @(posedge clk) re_seen <= bus_re;

    always @(negedge clk) begin
        if (re_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== {e, 32'h0}) begin
                errors++;
                $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, {e, 32'h0});
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        finish_run();
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = {d, 32'hA5A5_5A5A};
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_evt(input logic [3:0] a, input logic [31:0] d, input logic [7:0] ev);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = {d, 32'h0}; evt_in = ev;
        @(negedge clk);
        bus_we = 1'b0; evt_in = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic rd_evt(input logic [3:0] a, input logic [31:0] e, input logic [7:0] ev, input string t);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a; evt_in = ev;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_re = 1'b0; evt_in = '0;
    endtask

    task automatic pulse(input logic [7:0] ev, input int n);
        @(negedge clk);
        evt_in = ev;
        repeat (n) @(negedge clk);
        evt_in = '0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq=%b expected=%b", t, irq, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on every register
        chk_irq(1'b0, "R1 irq after reset");
        for (int a = 0; a < 10; a++) rd(4'(a), 32'h0, "R1 reset readback");

        // R3: latch readback while disabled, no live change on events
        wr(4'd0, 32'h1111_2222);
        pulse(8'h01, 3);
        rd(4'd0, 32'h1111_2222, "R3 pending latch readback");
        // R4: commit; R5: counting; R6: both indices see 32 bits
        wr(4'd8, 32'h8000_0000);
        rd(4'd0, 32'h1111_2222, "R4 committed value");
        pulse(8'h01, 5);
        rd(4'd0, 32'h1111_2227, "R5 counted five events");
        rd(4'd4, 32'h1111_2227, "R6 alias index full width");

        // R3: write while enabled shows live; R4: re-commit when enabled
        wr(4'd1, 32'h5);
        rd(4'd1, 32'h0, "R3 live shown after enabled write");
        wr(4'd8, 32'h8000_0000);
        rd(4'd1, 32'h5, "R4 re-commit while enabled");
        rd(4'd0, 32'h1111_2227, "R4 unwritten counter kept");

        // R5: disable stops counting
        wr(4'd8, 32'h0);
        pulse(8'h01, 4);
        rd(4'd0, 32'h1111_2227, "R5 disabled holds value");

        // R4: commit beats a same-clock event
        wr(4'd8, 32'h8000_0000);
        wr(4'd2, 32'h100);
        wr_evt(4'd8, 32'h8000_0000, 8'h04);
        rd(4'd2, 32'h100, "R4 commit wins over event");

        // R6: 32-bit wrap sets status bit 3; R10: mask zero, no irq
        wr(4'd3, 32'hFFFF_FFFE);
        wr(4'd8, 32'h8000_0000);
        pulse(8'h08, 3);
        rd(4'd3, 32'h1, "R6 32-bit wrap");
        chk_irq(1'b0, "R10 masked overflow quiet");
        rd(4'd9, 32'h08, "R6 status bit on wrap");
        rd(4'd9, 32'h0, "R9 status cleared by read");

        // R10: mask enables irq, read clears it, zero mask drops it
        wr(4'd9, 32'h08);
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd8, 32'h8000_0000);
        pulse(8'h08, 1);
        chk_irq(1'b1, "R10 enabled overflow raises irq");
        rd(4'd9, 32'h08, "R10 status with irq");
        chk_irq(1'b0, "R9 irq gone after read");
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd8, 32'h8000_0000);
        pulse(8'h08, 1);
        chk_irq(1'b1, "R10 irq again");
        wr(4'd9, 32'h0);
        chk_irq(1'b0, "R10 zero mask drops irq");
        rd(4'd9, 32'h08, "R10 status kept under zero mask");

        // R9: overflow in the clearing clock is kept
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd8, 32'h8000_0000);
        rd_evt(4'd9, 32'h0, 8'h08, "R9 read during overflow");
        rd(4'd9, 32'h08, "R9 coincident overflow kept");

        // R7: split counter 0
        wr(4'd8, 32'h8000_0001);
        rd(4'd0, 32'h1111, "R7 upper half read");
        rd(4'd4, 32'h2227, "R7 lower half read");
        wr(4'd4, 32'hFFFE);
        rd(4'd4, 32'h2227, "R3 enabled half write shows live");
        wr(4'd8, 32'h8000_0001);
        pulse(8'h10, 3);
        rd(4'd4, 32'h1, "R8 lower half wrap");
        rd(4'd0, 32'h1111, "R8 no carry into upper");
        rd(4'd9, 32'h10, "R8 lower overflow bit");
        pulse(8'h01, 2);
        rd(4'd0, 32'h1113, "R7 upper counts own event");
        rd(4'd4, 32'h1, "R7 lower unaffected");
        wr(4'd0, 32'hFFFF);
        wr(4'd8, 32'h8000_0001);
        pulse(8'h01, 1);
        rd(4'd9, 32'h01, "R8 upper overflow bit");
        rd(4'd0, 32'h0, "R8 upper wrap");
        rd(4'd4, 32'h1, "R7 lower kept on upper write");

        // R11: unmapped address; R2: control readback
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd12, 32'h0, "R11 unmapped reads zero");
        rd(4'd8, 32'h8000_0001, "R2 control readback");

        // R3/R7: pending half write while disabled
        wr(4'd8, 32'h1);
        wr(4'd4, 32'hABCD);
        rd(4'd4, 32'hABCD, "R3 pending lower half");
        rd(4'd0, 32'h0, "R7 pending upper merged");
        pulse(8'h11, 2);
        wr(4'd8, 32'h8000_0001);
        rd(4'd4, 32'hABCD, "R4 split commit");
        pulse(8'h10, 1);
        rd(4'd4, 32'hABCE, "R7 lower counts after commit");

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule